// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block performs register-context switches for a processor that keeps its sixteen general registers in external memory, starting at the address held in a workspace pointer. It owns the three on-chip registers of such a processor (program counter, workspace pointer and status word). It runs the memory reads and writes needed to move from one register context to another over a single word-wide request/acknowledge memory port. The instruction sequencer hands it an already decoded operation code with its operand values. It reports back through a busy level and a one-cycle done pulse.

Five kinds of switch are supported: a vectored call, the matching return, a numbered software trap, a branch-and-link, and hardware interrupts (maskable with a 4-bit level, plus a non-maskable input). There is no stack. A call, trap or interrupt fetches a two-word vector (new workspace pointer first, new program counter second). It then stores the old workspace pointer, program counter and status word into registers 13, 14 and 15 of the new workspace. The return reads them back from the current workspace in the opposite order. Whether a maskable request is taken depends on its level compared against the mask in the low four bits of the status word.

Top module: `ctx_switch_seq`

## Requirements
- R1: After reset, cur_pc, cur_wp and cur_st are all zero, busy and done are low, and no memory request is made.
- R2: Operation code 1 (call) with op_valid reads the new workspace pointer at op_addr and the new program counter at op_addr+2. It then writes the old workspace pointer, program counter and status word to new workspace registers 13, 14 and 15, in that order. At the end it takes the new pointer and counter and keeps the status word.
- R3: Operation code 2 (return) reads register 15, then 14, then 13 of the current workspace into the status word, program counter and workspace pointer respectively, and never writes memory.
- R4: Operation code 4 (branch-and-link) writes the current program counter into register 11 of the current workspace, sets the program counter to op_addr, and leaves the workspace pointer and status word unchanged.
- R5: Operation code 3 (trap) with number k (op_num, 0 to 15) switches through the vector at TRAP_BASE+4k exactly as in R2. After the saves it also writes op_addr into register 11 of the new workspace.
- R6: A maskable request of level L is accepted only when L is less than or equal to cur_st[3:0]. It switches through the vector at IRQ_BASE+4L, saves the old status word unchanged, and loads cur_st[3:0] with L-1 (0 when L is 0), keeping cur_st[15:4].
- R7: The nmi input switches through the vector at NMI_VEC whatever the mask holds, loads cur_st[3:0] with 0, and wins over a maskable request present in the same cycle.
- R8: Interrupts are sampled only while the block is idle and op_valid is low. An operation offered while idle is taken in preference to any pending interrupt.
- R9: busy is high from the cycle after an operation or interrupt is accepted until the switch ends. done is a one-cycle pulse, with busy low, in the cycle where the new register values first appear. cur_pc, cur_wp and cur_st do not change at any other time.
- R10: At most one word access is outstanding. mem_req, mem_we and mem_addr hold steady until mem_ack, and op_valid while busy has no effect.
- R11: Workspace register n lies at cur_wp+2n, and all address sums wrap modulo 2^16. Every address driven on mem_addr has bit 0 forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A decoded operation is offered |
| op_kind | input | 3 | Operation code: 1 call, 2 return, 3 trap, 4 branch-and-link |
| op_num | input | 4 | Trap number |
| op_addr | input | 16 | Call vector address, link target, or trap source address |
| irq_req | input | 1 | Maskable interrupt request |
| irq_level | input | 4 | Level of the maskable request |
| nmi | input | 1 | Non-maskable load request |
| busy | output | 1 | A switch is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address, always even |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| cur_pc | output | 16 | Program counter |
| cur_wp | output | 16 | Workspace pointer |
| cur_st | output | 16 | Status word, mask in bits 3:0 |

## Verification
A wrong vector or workspace address shows up at mem_addr in the very cycle of the faulty request. It reaches memory contents when that access is acknowledged, so the bench compares its whole shadow memory image after every switch. A wrong captured word or a bad commit only appears on cur_pc, cur_wp and cur_st in the done cycle, and a wrong saved word may stay hidden until a later return reads it back. For that reason random sequences mix calls, traps and interrupts with returns. A wrong mask decision shows up within one cycle of the request as busy rising, or failing to rise, against the bench's own acceptance rule.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    localparam int WORD_W = 16;
    localparam int SLOT_W = 4;

    // operation codes presented by the instruction sequencer
    localparam logic [2:0] OPC_CALL = 3'd1;
    localparam logic [2:0] OPC_RET  = 3'd2;
    localparam logic [2:0] OPC_TRAP = 3'd3;
    localparam logic [2:0] OPC_LINK = 3'd4;

    // workspace slots used by the switches
    localparam logic [SLOT_W-1:0] SLOT_LINK  = 4'd11;
    localparam logic [SLOT_W-1:0] SLOT_OLDWP = 4'd13;
    localparam logic [SLOT_W-1:0] SLOT_OLDPC = 4'd14;
    localparam logic [SLOT_W-1:0] SLOT_OLDST = 4'd15;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VEC_WP,
        S_VEC_PC,
        S_SAVE_WP,
        S_SAVE_PC,
        S_SAVE_ST,
        S_SAVE_SRC,
        S_LOAD_ST,
        S_LOAD_PC,
        S_LOAD_WP,
        S_LINK
    } state_e;

    typedef enum logic [2:0] {
        SW_CALL,
        SW_RET,
        SW_TRAP,
        SW_LINK,
        SW_IRQ,
        SW_NMI
    } sw_e;

    typedef struct packed {
        state_e              state;
        sw_e                 sw;
        logic [WORD_W-1:0]   vec;
        logic [WORD_W-1:0]   aux;
        logic [WORD_W-1:0]   new_wp;
        logic [WORD_W-1:0]   new_pc;
        logic [WORD_W-1:0]   new_st;
        logic [WORD_W-1:0]   pc;
        logic [WORD_W-1:0]   wp;
        logic [WORD_W-1:0]   st;
        logic                done;
    } ctx_t;

    function automatic logic [SLOT_W-1:0] slot_of(state_e s);
        case (s)
            S_SAVE_WP, S_LOAD_WP: return SLOT_OLDWP;
            S_SAVE_PC, S_LOAD_PC: return SLOT_OLDPC;
            S_SAVE_ST, S_LOAD_ST: return SLOT_OLDST;
            default:              return SLOT_LINK;
        endcase
    endfunction

endpackage

// File: rtl/ctx_irq_arb.sv
module ctx_irq_arb #(
    parameter int LEVEL_W = 4
) (
    input  logic               irq_req,
    input  logic [LEVEL_W-1:0] irq_level,
    input  logic               nmi,
    input  logic [LEVEL_W-1:0] mask,
    output logic               take,
    output logic               take_nmi,
    output logic [LEVEL_W-1:0] mask_d
);

    logic lvl_ok;

    // R6: a level at or below the mask value is admitted
    assign lvl_ok   = irq_req && (irq_level <= mask);
    // R7: the non-maskable input ignores the mask and wins
    assign take_nmi = nmi;
    assign take     = nmi || lvl_ok;

    always_comb begin
        if (nmi) begin
            mask_d = '0;
        end else if (irq_level == '0) begin
            mask_d = '0;
        end else begin
            mask_d = irq_level - 1'b1;
        end
    end

endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen
    import ctx_pkg::*;
(
    input  state_e            state,
    input  logic [WORD_W-1:0] wp,
    input  logic [WORD_W-1:0] new_wp,
    input  logic [WORD_W-1:0] vec,
    output logic [WORD_W-1:0] addr
);

    logic [WORD_W-1:0] raw;
    logic [WORD_W-1:0] offs;

    // R11: register n sits 2n bytes above its workspace base
    assign offs = WORD_W'({slot_of(state), 1'b0});

    always_comb begin
        case (state)
            S_VEC_WP:   raw = vec;
            S_VEC_PC:   raw = vec + WORD_W'(2);
            S_SAVE_WP,
            S_SAVE_PC,
            S_SAVE_ST,
            S_SAVE_SRC: raw = new_wp + offs;
            default:    raw = wp + offs;
        endcase
    end

    // R11: word accesses only
    assign addr = {raw[WORD_W-1:1], 1'b0};

endmodule

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq
    import ctx_pkg::*;
#(
    parameter int                LEVEL_W   = 4,
    parameter int                NUM_W     = 4,
    parameter logic [WORD_W-1:0] TRAP_BASE = 16'h0040,
    parameter logic [WORD_W-1:0] IRQ_BASE  = 16'h0000,
    parameter logic [WORD_W-1:0] NMI_VEC   = 16'hFFFC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [2:0]         op_kind,
    input  logic [NUM_W-1:0]   op_num,
    input  logic [WORD_W-1:0]  op_addr,
    input  logic               irq_req,
    input  logic [LEVEL_W-1:0] irq_level,
    input  logic               nmi,
    output logic               busy,
    output logic               done,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WORD_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_ack,
    output logic [WORD_W-1:0]  cur_pc,
    output logic [WORD_W-1:0]  cur_wp,
    output logic [WORD_W-1:0]  cur_st
);

    localparam int VEC_SHIFT = 2;

    ctx_t q, d;

    logic               irq_take;
    logic               irq_is_nmi;
    logic [LEVEL_W-1:0] irq_mask;
    logic               fin;
    logic [WORD_W-1:0]  fin_wp;

    ctx_irq_arb #(.LEVEL_W(LEVEL_W)) u_arb (
        .irq_req  (irq_req),
        .irq_level(irq_level),
        .nmi      (nmi),
        .mask     (q.st[LEVEL_W-1:0]),
        .take     (irq_take),
        .take_nmi (irq_is_nmi),
        .mask_d   (irq_mask)
    );

    ctx_addr_gen u_addr (
        .state (q.state),
        .wp    (q.wp),
        .new_wp(q.new_wp),
        .vec   (q.vec),
        .addr  (mem_addr)
    );

    // R10: a request is open in every non-idle state
    assign busy    = (q.state != S_IDLE);
    assign mem_req = busy;
    assign done    = q.done;
    assign cur_pc  = q.pc;
    assign cur_wp  = q.wp;
    assign cur_st  = q.st;

    always_comb begin
        case (q.state)
            S_SAVE_WP,
            S_SAVE_PC,
            S_SAVE_ST,
            S_SAVE_SRC,
            S_LINK:  mem_we = 1'b1;
            default: mem_we = 1'b0;
        endcase
    end

    always_comb begin
        case (q.state)
            S_SAVE_WP:  mem_wdata = q.wp;
            S_SAVE_PC:  mem_wdata = q.pc;
            S_SAVE_ST:  mem_wdata = q.st;
            S_SAVE_SRC: mem_wdata = q.aux;
            S_LINK:     mem_wdata = q.pc;
            default:    mem_wdata = '0;
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        fin    = 1'b0;
        fin_wp = q.new_wp;
        case (q.state)
            S_IDLE: begin
                if (op_valid) begin
                    // R8: an offered operation beats a pending interrupt
                    d.new_wp = q.wp;
                    d.new_pc = q.pc;
                    d.new_st = q.st;
                    d.aux    = op_addr;
                    case (op_kind)
                        OPC_CALL: begin
                            d.sw    = SW_CALL;
                            d.vec   = op_addr;
                            d.state = S_VEC_WP;
                        end
                        OPC_TRAP: begin
                            d.sw    = SW_TRAP;
                            d.vec   = TRAP_BASE + (WORD_W'(op_num) << VEC_SHIFT);
                            d.state = S_VEC_WP;
                        end
                        OPC_RET: begin
                            d.sw    = SW_RET;
                            d.state = S_LOAD_ST;
                        end
                        OPC_LINK: begin
                            d.sw     = SW_LINK;
                            d.new_pc = op_addr;
                            d.state  = S_LINK;
                        end
                        default: ;
                    endcase
                end else if (irq_take) begin
                    d.new_st                = q.st;
                    d.new_st[LEVEL_W-1:0]   = irq_mask;
                    d.sw                    = irq_is_nmi ? SW_NMI : SW_IRQ;
                    d.vec                   = irq_is_nmi ? NMI_VEC
                                            : IRQ_BASE + (WORD_W'(irq_level) << VEC_SHIFT);
                    d.state                 = S_VEC_WP;
                end
            end
            S_VEC_WP: if (mem_ack) begin
                d.new_wp = mem_rdata;
                d.state  = S_VEC_PC;
            end
            S_VEC_PC: if (mem_ack) begin
                d.new_pc = mem_rdata;
                d.state  = S_SAVE_WP;
            end
            S_SAVE_WP: if (mem_ack) d.state = S_SAVE_PC;
            S_SAVE_PC: if (mem_ack) d.state = S_SAVE_ST;
            S_SAVE_ST: if (mem_ack) begin
                if (q.sw == SW_TRAP) begin
                    d.state = S_SAVE_SRC;
                end else begin
                    fin = 1'b1;
                end
            end
            S_SAVE_SRC: if (mem_ack) fin = 1'b1;
            S_LOAD_ST: if (mem_ack) begin
                d.new_st = mem_rdata;
                d.state  = S_LOAD_PC;
            end
            S_LOAD_PC: if (mem_ack) begin
                d.new_pc = mem_rdata;
                d.state  = S_LOAD_WP;
            end
            S_LOAD_WP: if (mem_ack) begin
                fin    = 1'b1;
                fin_wp = mem_rdata;
            end
            S_LINK: if (mem_ack) fin = 1'b1;
            default: d.state = S_IDLE;
        endcase

        // R9: the architectural registers move only on completion
        if (fin) begin
            d.state = S_IDLE;
            d.done  = 1'b1;
            d.wp    = fin_wp;
            d.pc    = q.new_pc;
            d.st    = q.new_st;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ctx_switch_chk.sv
module ctx_switch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [2:0]  op_kind,
    input logic        nmi,
    input logic        busy,
    input logic        done,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [15:0] mem_addr,
    input logic [15:0] cur_pc,
    input logic [15:0] cur_wp,
    input logic [15:0] cur_st
);

    logic in_ret;
    logic nmi_tk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ret <= 1'b0;
            nmi_tk <= 1'b0;
        end else if (!busy) begin
            in_ret <= op_valid && (op_kind == 3'd2);
            nmi_tk <= !op_valid && nmi;
        end
    end

    p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_addr_even_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[0] == 1'b0));

    p_regs_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ack) |=> ($stable(cur_pc) && $stable(cur_wp) && $stable(cur_st)));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ret_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_ret && mem_req) |-> !mem_we);

    p_nmi_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nmi_tk) |-> (cur_st[3:0] == 4'd0));

endmodule

bind ctx_switch_seq ctx_switch_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_valid(op_valid),
    .op_kind (op_kind),
    .nmi     (nmi),
    .busy    (busy),
    .done    (done),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_ack (mem_ack),
    .mem_addr(mem_addr),
    .cur_pc  (cur_pc),
    .cur_wp  (cur_wp),
    .cur_st  (cur_st)
);

// File: tb/tb_ctx_switch_seq.sv
module tb_ctx_switch_seq;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] TRAP_BASE  = 16'h0040;
    localparam logic [15:0] IRQ_BASE   = 16'h0000;
    localparam logic [15:0] NMI_VEC    = 16'hFFFC;
    localparam logic [2:0]  K_CALL = 3'd1, K_RET = 3'd2, K_TRAP = 3'd3, K_LINK = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [3:0]  op_num = '0;
    logic [15:0] op_addr = '0;
    logic        irq_req = 1'b0;
    logic [3:0]  irq_level = '0;
    logic        nmi = 1'b0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, cur_pc, cur_wp, cur_st;
    logic [15:0] mem_rdata;
    logic        mem_ack;

    ctx_switch_seq #(
        .TRAP_BASE(TRAP_BASE), .IRQ_BASE(IRQ_BASE), .NMI_VEC(NMI_VEC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_num(op_num), .op_addr(op_addr), .irq_req(irq_req),
        .irq_level(irq_level), .nmi(nmi), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cur_pc(cur_pc), .cur_wp(cur_wp), .cur_st(cur_st)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: 256 words, indexed by address bits 8:1
    logic [15:0] mem [0:255];
    logic [1:0]  wcnt;
    bit          odd_seen = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= '0;
            for (int i = 0; i < 256; i++) mem[i] <= 16'($urandom);
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (mem_addr[0]) odd_seen <= 1'b1;
                if (wcnt == 0) begin
                    mem_ack <= 1'b1;
                    if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
                    else        mem_rdata <= mem[mem_addr[8:1]];
                    wcnt <= 2'($urandom % 3);
                end else begin
                    wcnt <= wcnt - 1'b1;
                end
            end
        end
    end

    // bench reference model
    logic [15:0] sh [0:255];
    logic [15:0] m_pc, m_wp, m_st;
    int n_run = 0, n_fail = 0;

    function automatic logic [7:0] ix(input logic [15:0] a);
        return a[8:1];
    endfunction

    function automatic logic [3:0] lvl_mask(input logic [3:0] l);
        return (l == 4'd0) ? 4'd0 : l - 4'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic m_switch(input logic [15:0] va, input logic [15:0] nst,
                            input bit trap, input logic [15:0] src);
        logic [15:0] nwp, npc;
        nwp = sh[ix(va)];
        npc = sh[ix(va + 16'd2)];
        sh[ix(nwp + 16'd26)] = m_wp;
        sh[ix(nwp + 16'd28)] = m_pc;
        sh[ix(nwp + 16'd30)] = m_st;
        if (trap) sh[ix(nwp + 16'd22)] = src;
        m_wp = nwp;
        m_pc = npc;
        m_st = nst;
    endtask

    task automatic m_ret();
        logic [15:0] b;
        b    = m_wp;
        m_st = sh[ix(b + 16'd30)];
        m_pc = sh[ix(b + 16'd28)];
        m_wp = sh[ix(b + 16'd26)];
    endtask

    task automatic m_link(input logic [15:0] t);
        sh[ix(m_wp + 16'd22)] = m_pc;
        m_pc = t;
    endtask

    task automatic verify(input string req);
        int bad;
        int bi;
        bad = 0;
        bi  = 0;
        chk(cur_pc == m_pc, req, "cur_pc", cur_pc, m_pc);
        chk(cur_wp == m_wp, req, "cur_wp", cur_wp, m_wp);
        chk(cur_st == m_st, req, "cur_st", cur_st, m_st);
        for (int i = 0; i < 256; i++) begin
            if (mem[i] !== sh[i]) begin
                if (bad == 0) bi = i;
                bad++;
            end
        end
        chk(bad == 0, req, "memory image", mem[bi], sh[bi]);
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_op(input logic [2:0] kind, input logic [3:0] num,
                          input logic [15:0] addr, input bit junk, input string req);
        bit ok;
        @(negedge clk);
        op_valid = 1'b1; op_kind = kind; op_num = num; op_addr = addr;
        @(negedge clk);
        chk(busy == 1'b1, "R9", "busy after accept", 16'(busy), 16'd1);
        if (junk) begin
            // R10: an offer while busy must be ignored
            op_kind = K_LINK; op_addr = 16'h5A5A;
            @(negedge clk);
        end
        op_valid = 1'b0;
        wait_done(ok);
        chk(ok, req, "done seen", 16'(ok), 16'd1);
        chk(busy == 1'b0, "R9", "busy at done", 16'(busy), 16'd0);
        case (kind)
            K_CALL:  m_switch(addr, m_st, 1'b0, '0);
            K_TRAP:  m_switch(TRAP_BASE + 16'(num) * 16'd4, m_st, 1'b1, addr);
            K_RET:   m_ret();
            default: m_link(addr);
        endcase
        verify(junk ? "R10" : req);
    endtask

    task automatic run_irq(input bit irq_on, input logic [3:0] lvl,
                           input bit nmi_on, input string req);
        bit ok, take;
        take = nmi_on || (irq_on && (lvl <= m_st[3:0]));
        @(negedge clk);
        irq_req = irq_on; irq_level = lvl; nmi = nmi_on;
        @(negedge clk);
        chk(busy == take, req, "acceptance", 16'(busy), 16'(take));
        if (take) begin
            irq_req = 1'b0; nmi = 1'b0;
            wait_done(ok);
            chk(ok, req, "done seen", 16'(ok), 16'd1);
            if (nmi_on) m_switch(NMI_VEC, {m_st[15:4], 4'd0}, 1'b0, '0);
            else        m_switch(IRQ_BASE + 16'(lvl) * 16'd4,
                                 {m_st[15:4], lvl_mask(lvl)}, 1'b0, '0);
        end else begin
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                chk(!busy && !mem_req, req, "rejected stays idle", 16'(busy), 16'd0);
            end
            irq_req = 1'b0; nmi = 1'b0;
        end
        verify(req);
    endtask

    bit summary_done = 1'b0;

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit ok;
        logic [3:0] l;
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 256; i++) sh[i] = mem[i];
        m_pc = '0; m_wp = '0; m_st = '0;

        // R1: reset state
        chk(cur_pc == 16'd0 && cur_wp == 16'd0 && cur_st == 16'd0, "R1",
            "registers", cur_pc | cur_wp | cur_st, 16'd0);
        chk(!busy && !done && !mem_req, "R1", "idle outputs",
            16'({busy, done, mem_req}), 16'd0);

        // directed cases
        run_op(K_LINK, 4'd0, 16'h0122, 1'b0, "R4");
        run_op(K_CALL, 4'd0, 16'h0080, 1'b0, "R2");
        run_op(K_TRAP, 4'd0, 16'hBEEF, 1'b0, "R5");
        run_op(K_TRAP, 4'd15, 16'h1357, 1'b0, "R5");
        run_op(K_RET, 4'd0, 16'h0000, 1'b0, "R3");
        run_op(K_CALL, 4'd0, 16'h0091, 1'b0, "R11");
        run_op(K_LINK, 4'd0, 16'h0200, 1'b1, "R10");

        // R6: boundary at the mask, then the same level after acceptance
        l = m_st[3:0];
        run_irq(1'b1, l, 1'b0, "R6");
        run_irq(1'b1, l, 1'b0, "R6");
        if (m_st[3:0] != 4'd15) run_irq(1'b1, m_st[3:0] + 4'd1, 1'b0, "R6");
        run_irq(1'b1, 4'd0, 1'b0, "R6");

        // R7: non-maskable alone and against a maskable request
        run_irq(1'b0, 4'd0, 1'b1, "R7");
        run_irq(1'b1, 4'd0, 1'b1, "R7");
        run_op(K_RET, 4'd0, 16'h0000, 1'b0, "R3");

        // R8: offered operation beats a pending interrupt
        @(negedge clk);
        op_valid = 1'b1; op_kind = K_LINK; op_addr = 16'h0144; nmi = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        wait_done(ok);
        nmi = 1'b0;
        chk(ok, "R8", "done seen", 16'(ok), 16'd1);
        m_link(16'h0144);
        verify("R8");
        @(negedge clk);
        chk(!busy, "R8", "interrupt dropped before sampling", 16'(busy), 16'd0);

        // constrained random mix
        for (int it = 0; it < 160; it++) begin
            int sel;
            sel = int'($urandom % 6);
            case (sel)
                0: run_op(K_CALL, 4'd0, 16'($urandom), ($urandom % 8) == 0, "R2");
                1: run_op(K_RET, 4'd0, 16'd0, ($urandom % 8) == 0, "R3");
                2: run_op(K_TRAP, 4'($urandom), 16'($urandom), 1'b0, "R5");
                3: run_op(K_LINK, 4'd0, 16'($urandom), ($urandom % 8) == 0, "R4");
                4: run_irq(1'b1, 4'($urandom), 1'b0, "R6");
                default: run_irq(($urandom % 2) == 1, 4'($urandom), 1'b1, "R7");
            endcase
        end

        chk(!odd_seen, "R11", "odd address seen", 16'(odd_seen), 16'd0);
        finish_run();
    end

endmodule